// File: doc/BRIEF.md
# Serial Video Word Framer

This block sits in a serial digital video receiver after the line decoder. Each serial clock brings one decoded bit. The block watches the bit stream for the timing reference sequence that marks the start and end of every active video line. It uses that sequence to fix where each 10-bit word begins. It then assembles the stream into parallel words, which are sent least significant bit first, and produces a word-rate clock divided down from the serial clock.

The block flags the four words of every accepted timing reference on an active-low output. In component mode it also marks the fourth word (the XYZ word) on an end-of-active-video output when that word is an end reference. A reference found at a bit position other than the current word grid is reported on a new-position flag. The framer moves its word grid onto such a reference only when the frame-enable input allows it. The one exception is the first reference after reset, which the framer always takes.

Top module: `sdv_framer`

## Requirements
- R1: Serial bits are grouped into 10-bit words. The first bit received of a word lands in bit 0 of `word_data`. Each word appears on `word_data` three word periods after it completes and is held for one word period.
- R2: Once aligned, `word_clk` has a period of 10 serial clocks. It is low for the 5 cycles after `word_data` changes and high for the remaining 5, so it rises only while `word_data` is stable.
- R3: A timing reference is ten 1 bits followed by twenty 0 bits, which are the words 0x3FF, 0x000 and 0x000. The sequence is accepted when it ends on the current word grid or when a realignment is permitted. For an accepted reference, `trs_n` is low for the 40 cycles during which 0x3FF, 0x000, 0x000 and the following XYZ word are presented. The first low cycle shows 0x3FF.
- R4: In component mode (`composite` = 0), `eav_n` is low for the 10 cycles in which the XYZ word is presented, provided bit 6 of that word is 1. It stays high when bit 6 is 0, and it is low only while `trs_n` is low.
- R5: In composite mode (`composite` = 1), `eav_n` is held high.
- R6: After reset, the first timing reference found sets the word grid whatever the level of `frame_en`.
- R7: After the first alignment, a reference at a new bit position moves the word grid only if `frame_en` is 1 on the cycle its pattern completes. Otherwise the grid is kept and that reference is not flagged on `trs_n`.
- R8: `new_pos` goes to 1 when a reference completes off the current word grid and no realignment takes place. It returns to 0 when the word grid is next realigned. A realignment made at the same reference leaves it at 0.
- R9: While `rst` is 1, the outputs take the following values at the next clock edge: `trs_n`=1, `eav_n`=1, `new_pos`=0, `word_clk`=0 and `word_data`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_bit | input | 1 | Decoded serial data bit |
| frame_en | input | 1 | Permits moving the word grid at a reference |
| composite | input | 1 | 1 selects composite mode, 0 component mode |
| word_data | output | 10 | Parallel output word |
| word_clk | output | 1 | Word-rate clock, rising mid-word |
| trs_n | output | 1 | Low while a timing reference is presented |
| eav_n | output | 1 | Low while an end-reference XYZ word is presented |
| new_pos | output | 1 | A reference was seen off the current word grid |

## Verification
The assertions check several rules on every cycle. They cover the reset values, the rule that `eav_n` is held high in composite mode, and the rule that `eav_n` is low only inside a flagged reference on a word with bit 6 set. They also check that a flagged reference always begins with 0x3FF, that `word_data` is stable when `word_clk` rises, and that `new_pos` is raised only after `frame_en` was low. Other behaviour needs a particular stream and can only be shown by the bench's scenarios. This includes the LSB-first bit order and the three-word delay, the first lock while `frame_en` is low, and a bit slip that is ignored and flagged and then realigned once `frame_en` is raised. It also includes the 40-cycle length of the flag and the difference between start and end references.

// File: rtl/sdv_frm_pkg.sv
package sdv_frm_pkg;

    localparam int WORD_W    = 10;                 // bits per parallel word
    localparam int LEAD_WRDS = 3;                  // words of the fixed reference prefix
    localparam int PAT_W     = LEAD_WRDS * WORD_W; // bits searched for the prefix
    localparam int PH_W      = $clog2(WORD_W);     // width of a bit-phase counter
    localparam int HI_FROM   = WORD_W / 2;         // word-clock high from this phase
    localparam int H_BIT     = 6;                  // XYZ bit that marks an end reference

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t ALL_ONES  = '1;
    localparam word_t ALL_ZEROS = '0;

    typedef struct packed {
        word_t data;
        logic  trs;
        logic  eav;
    } slot_t;

    // oldest bit sits at index 0: ten ones first, then twenty zeros
    function automatic logic prefix_match(input logic [PAT_W-1:0] sh);
        return (sh[WORD_W-1:0] == ALL_ONES) && (sh[PAT_W-1:WORD_W] == '0);
    endfunction

endpackage

// File: rtl/sdv_trs_hunter.sv
module sdv_trs_hunter
    import sdv_frm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ser_bit,
    output word_t last_word,
    output logic  hit
);

    logic [PAT_W-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else begin
            hist <= {ser_bit, hist[PAT_W-1:1]};
        end
    end

    assign hit       = prefix_match(hist);
    assign last_word = hist[PAT_W-1 -: WORD_W];

endmodule

// File: rtl/sdv_word_phase.sv
module sdv_word_phase
    import sdv_frm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic frame_en,
    output logic cap,
    output logic ref_ok,
    output logic word_clk,
    output logic new_pos
);

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] oph;
    logic            locked;
    logic            at_edge;
    logic            allow;
    logic            realign;

    assign at_edge = (ph == '0);
    assign allow   = frame_en | ~locked;
    assign realign = hit & allow;
    assign cap     = at_edge | realign;
    assign ref_ok  = hit & (at_edge | allow);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= '0;
            oph     <= '0;
            locked  <= 1'b0;
            new_pos <= 1'b0;
        end else begin
            if (realign) begin
                ph <= PH_W'(1);
            end else if (ph == PH_W'(WORD_W - 1)) begin
                ph <= '0;
            end else begin
                ph <= ph + PH_W'(1);
            end

            if (cap) begin
                oph <= '0;
            end else if (oph != PH_W'(WORD_W - 1)) begin
                oph <= oph + PH_W'(1);
            end

            locked <= locked | realign;

            if (realign) begin
                new_pos <= 1'b0;
            end else if (hit && !at_edge) begin
                new_pos <= 1'b1;
            end
        end
    end

    assign word_clk = (oph >= PH_W'(HI_FROM));

endmodule

// File: rtl/sdv_word_pipe.sv
module sdv_word_pipe
    import sdv_frm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap,
    input  logic  ref_ok,
    input  word_t new_word,
    output slot_t out_slot
);

    slot_t stg [LEAD_WRDS];
    slot_t fresh;
    logic  pend;

    always_comb begin
        fresh.data = new_word;
        fresh.trs  = pend;
        fresh.eav  = pend & new_word[H_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_slot <= '0;
            pend     <= 1'b0;
            for (int i = 0; i < LEAD_WRDS; i++) begin
                stg[i] <= '0;
            end
        end else if (cap) begin
            out_slot <= stg[LEAD_WRDS-1];
            if (ref_ok) begin
                // the matched prefix is known bit for bit: rebuild it on the new grid
                stg[0] <= slot_t'{data: new_word, trs: 1'b1, eav: 1'b0};
                for (int i = 1; i < LEAD_WRDS - 1; i++) begin
                    stg[i] <= slot_t'{data: ALL_ZEROS, trs: 1'b1, eav: 1'b0};
                end
                stg[LEAD_WRDS-1] <= slot_t'{data: ALL_ONES, trs: 1'b1, eav: 1'b0};
                pend <= 1'b1;
            end else begin
                stg[0] <= fresh;
                for (int i = 1; i < LEAD_WRDS; i++) begin
                    stg[i] <= stg[i-1];
                end
                pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdv_framer.sv
module sdv_framer
    import sdv_frm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_bit,
    input  logic              frame_en,
    input  logic              composite,
    output logic [WORD_W-1:0] word_data,
    output logic              word_clk,
    output logic              trs_n,
    output logic              eav_n,
    output logic              new_pos
);

    word_t last_word;
    logic  hit;
    logic  cap;
    logic  ref_ok;
    slot_t out_slot;

    sdv_trs_hunter u_hunt (
        .clk       (clk),
        .rst       (rst),
        .ser_bit   (ser_bit),
        .last_word (last_word),
        .hit       (hit)
    );

    sdv_word_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .frame_en (frame_en),
        .cap      (cap),
        .ref_ok   (ref_ok),
        .word_clk (word_clk),
        .new_pos  (new_pos)
    );

    sdv_word_pipe u_pipe (
        .clk      (clk),
        .rst      (rst),
        .cap      (cap),
        .ref_ok   (ref_ok),
        .new_word (last_word),
        .out_slot (out_slot)
    );

    assign word_data = out_slot.data;
    assign trs_n     = ~out_slot.trs;
    assign eav_n     = composite | ~out_slot.eav;

endmodule

// File: rtl/sdv_framer_chk.sv
module sdv_framer_chk
    import sdv_frm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frame_en,
    input logic              composite,
    input logic [WORD_W-1:0] word_data,
    input logic              word_clk,
    input logic              trs_n,
    input logic              eav_n,
    input logic              new_pos
);

    // R9: reset values
    a_r9_reset_outputs: assert property (@(posedge clk)
        rst |=> (trs_n && eav_n && !new_pos && !word_clk && word_data == '0));

    // R5: composite mode never marks an end reference
    a_r5_composite_high: assert property (@(posedge clk) disable iff (rst)
        composite |-> eav_n);

    // R4: end mark only inside a reference, on a word with the H bit set
    a_r4_eav_in_trs: assert property (@(posedge clk) disable iff (rst)
        !eav_n |-> (!trs_n && word_data[H_BIT]));

    // R3: a flagged reference opens with the all-ones word
    a_r3_trs_starts_ones: assert property (@(posedge clk) disable iff (rst)
        $fell(trs_n) |-> (word_data == ALL_ONES));

    // R2: word clock rises inside a stable data window
    a_r2_rise_stable: assert property (@(posedge clk) disable iff (rst)
        $rose(word_clk) |-> $stable(word_data));

    // R8: a new position is only held when realignment was refused
    a_r8_newpos_refused: assert property (@(posedge clk) disable iff (rst)
        $rose(new_pos) |-> !$past(frame_en));

endmodule

bind sdv_framer sdv_framer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_en  (frame_en),
    .composite (composite),
    .word_data (word_data),
    .word_clk  (word_clk),
    .trs_n     (trs_n),
    .eav_n     (eav_n),
    .new_pos   (new_pos)
);

// File: tb/tb_sdv_framer.sv
module tb_sdv_framer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_bit = 1'b0;
    logic       frame_en = 1'b0;
    logic       composite = 1'b0;
    logic [9:0] word_data;
    logic       word_clk;
    logic       trs_n;
    logic       eav_n;
    logic       new_pos;

    always #4 clk = ~clk;

    sdv_framer dut (
        .clk       (clk),
        .rst       (rst),
        .ser_bit   (ser_bit),
        .frame_en  (frame_en),
        .composite (composite),
        .word_data (word_data),
        .word_clk  (word_clk),
        .trs_n     (trs_n),
        .eav_n     (eav_n),
        .new_pos   (new_pos)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_hist[$];
    int vq[$];
    int tq[$];
    int eq[$];
    int m_ph, m_oph, m_lock, m_np, m_pend;
    int mo_d, mo_t, mo_e;

    always @(posedge clk) begin
        if (rst) begin
            m_hist.delete();
            for (int i = 0; i < 30; i++) m_hist.push_back(1'b0);
            vq = '{0, 0, 0};
            tq = '{0, 0, 0};
            eq = '{0, 0, 0};
            m_ph = 0; m_oph = 0; m_lock = 0; m_np = 0; m_pend = 0;
            mo_d = 0; mo_t = 0; mo_e = 0;
        end else begin
            bit hit;
            bit allow, realign, take, ok_ref;
            int w;
            hit = 1'b1;
            for (int i = 0; i < 30; i++)
                if (m_hist[i] != (i < 10)) hit = 1'b0;
            w = 0;
            for (int i = 0; i < 10; i++)
                if (m_hist[20 + i]) w += (1 << i);
            allow   = frame_en || (m_lock == 0);
            realign = hit && allow;
            take    = (m_ph == 0) || realign;
            ok_ref  = hit && ((m_ph == 0) || allow);
            if (take) begin
                mo_d = vq[2]; mo_t = tq[2]; mo_e = eq[2];
                if (ok_ref) begin
                    vq = '{w, 0, 1023};
                    tq = '{1, 1, 1};
                    eq = '{0, 0, 0};
                    m_pend = 1;
                end else begin
                    vq.push_front(w);             void'(vq.pop_back());
                    tq.push_front(m_pend);        void'(tq.pop_back());
                    eq.push_front(m_pend && ((w >> 6) & 1)); void'(eq.pop_back());
                    m_pend = 0;
                end
                m_oph = 0;
            end else if (m_oph < 9) begin
                m_oph++;
            end
            if (realign) m_np = 0;
            else if (hit && m_ph != 0) m_np = 1;
            if (realign) m_lock = 1;
            m_ph = realign ? 1 : (m_ph + 1) % 10;
            m_hist.push_back(ser_bit);
            void'(m_hist.pop_front());
        end
    end

    // ---------------- per-cycle comparison and statistics ----------------
    bit started = 0;
    int trs_lo, eav_lo, np_hi, xyz_val;
    bit per_en = 0;
    int cyc = 0, last_rise = -1, bad_per = 0, rises = 0;
    bit prev_wclk = 0;

    always begin
        @(negedge clk);
        #1;
        cyc++;
        if (started) begin
            chk(word_data == mo_d[9:0], "R1", "word_data", word_data, mo_d);
            chk(word_clk == (m_oph >= 5), "R2", "word_clk", word_clk, m_oph >= 5);
            chk(trs_n == !mo_t, "R3", "trs_n", trs_n, !mo_t);
            chk(eav_n == (composite ? 1'b1 : !mo_e), "R4", "eav_n", eav_n,
                composite ? 1 : !mo_e);
            chk(new_pos == m_np[0], "R8", "new_pos", new_pos, m_np);
            if (!trs_n) trs_lo++;
            if (!eav_n) begin eav_lo++; xyz_val = word_data; end
            if (new_pos) np_hi++;
            if (word_clk && !prev_wclk) begin
                if (per_en && last_rise >= 0 && cyc - last_rise != 10) bad_per++;
                if (per_en) rises++;
                last_rise = cyc;
            end
            prev_wclk = word_clk;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_bit(input bit b);
        @(negedge clk);
        ser_bit = b;
    endtask

    task automatic send_word(input int w);
        for (int i = 0; i < 10; i++) send_bit(w[i]);
    endtask

    task automatic send_rand(input int n);
        for (int k = 0; k < n; k++) send_word(int'($urandom_range(1022, 1)));
    endtask

    task automatic scen(input int lead, input int xyz, input bit fe, input bit comp,
                        input int exp_trs, input int exp_eav, input string req);
        frame_en  = fe;
        composite = comp;
        trs_lo = 0; eav_lo = 0; np_hi = 0; xyz_val = -1;
        for (int i = 0; i < lead; i++) send_bit(i[0] == 0);
        send_rand(6);
        send_word(10'h3FF);
        send_word(10'h000);
        send_word(10'h000);
        send_word(xyz);
        send_rand(8);
        chk(trs_lo == exp_trs, req, "trs_n low cycles", trs_lo, exp_trs);
        chk(eav_lo == exp_eav, req, "eav_n low cycles", eav_lo, exp_eav);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R9: reset state
        chk(trs_n == 1'b1, "R9", "trs_n in reset", trs_n, 1);
        chk(eav_n == 1'b1, "R9", "eav_n in reset", eav_n, 1);
        chk(new_pos == 1'b0, "R9", "new_pos in reset", new_pos, 0);
        chk(word_clk == 1'b0, "R9", "word_clk in reset", word_clk, 0);
        chk(word_data == 10'h0, "R9", "word_data in reset", word_data, 0);
        started = 1;
        @(negedge clk);
        rst = 1'b0;

        // R6: first lock with frame_en low, 7-bit offset; end reference
        scen(7, 10'h274, 1'b0, 1'b0, 40, 10, "R6");
        chk(xyz_val == 10'h274, "R1", "XYZ word LSB-first", xyz_val, 10'h274);

        // R3/R4: aligned start reference, no end mark; R2 period
        per_en = 1;
        scen(0, 10'h200, 1'b0, 1'b0, 40, 0, "R4");
        per_en = 0;
        chk(bad_per == 0, "R2", "word_clk period mismatches", bad_per, 0);
        chk(rises >= 15, "R2", "word_clk rises", rises, 15);

        // R7/R8: 3-bit slip, realignment refused
        scen(3, 10'h274, 1'b0, 1'b0, 0, 0, "R7");
        chk(new_pos == 1'b1, "R8", "new_pos after refused move", new_pos, 1);

        // R7/R8: realignment permitted
        scen(0, 10'h274, 1'b1, 1'b0, 40, 10, "R7");
        chk(new_pos == 1'b0, "R8", "new_pos after realign", new_pos, 0);
        chk(np_hi > 0, "R8", "new_pos held until realign", np_hi, 1);

        // R5: composite mode
        scen(0, 10'h274, 1'b0, 1'b1, 40, 0, "R5");

        // R3: component again, aligned end reference with frame_en low
        scen(0, 10'h3C4, 1'b0, 1'b0, 40, 10, "R3");
        chk(xyz_val == 10'h3C4, "R4", "XYZ word shown with eav_n", xyz_val, 10'h3C4);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule